// File: doc/BRIEF.md
# Four-Channel DMA Register File with Byte-Pointer Access

This block holds the software-visible state of a four-channel DMA engine in the classic PC arrangement. A host reaches it through an 8-bit I/O port bus with a 4-bit offset. Each channel has a 16-bit current address and a 16-bit count. Each of these is reached through a single byte-wide port. One internal byte pointer, shared by all eight ports, chooses whether an access hits the low byte or the high byte. The block also holds per-channel mask bits, per-channel mode fields, a command register, a terminal-count status register, and two write-only strobes: one clears the pointer and one performs a master reset.

Data movement is outside this block. A per-channel step input stands for one completed transfer. On a step, the channel's count decrements and its address moves by one. When the count passes zero, the channel raises its terminal-count flag. It then either masks itself or reloads its start values, depending on its mode. Software programs a count equal to the transfer length minus one.

The port bus is a plain register interface. It has no back-pressure, so every write and read completes in the cycle it is presented. The mask bits are brought out as a plain control output.

Top module: `dma4_regs`

## Requirements
- R1: A write of any data to offset 0xC clears the shared byte pointer, so the next address or count access hits the low byte. If a clear and a pointer-toggling access could meet in one cycle, the clear wins.
- R2: Channel n (0..3) has its address port at offset 2n and its count port at offset 2n+1. A single pointer is shared by all eight ports and toggles on every read or write to offsets 0..7. Low byte is pointer 0; high byte is pointer 1. A write sets the selected byte of both the start copy and the working copy. A read returns the selected byte of the working copy.
- R3: A write to offset 0xA masks one channel. Data bits [1:0] select the channel. Data bit 2 set masks it, and bit 2 clear unmasks it. `mask_o[n]` is 1 when channel n is masked.
- R4: A write to offset 0xE clears all four mask bits. A write to offset 0xF loads all four from data bits [3:0]. After hardware reset all four mask bits are set.
- R5: A write to offset 0xB selects a channel with data bits [1:0] and stores its mode. Data bit 4 set enables auto-reload. Data bit 5 set makes the address count down; clear makes it count up.
- R6: A step on an unmasked channel, while the controller is enabled, moves its working address by one and decrements its working count. A step on a masked channel changes nothing.
- R7: When a step finds the working count at 0, the count wraps to 0xFFFF and the channel's status bit sets. With auto-reload, the working address and count reload from the start copies and the mask is unchanged. Without auto-reload, the channel's mask bit sets. A programmed count of N-1 therefore ends on the Nth step.
- R8: A read of offset 0x8 returns {4'b0000, tc[3:0]}, with bit n for channel n. The same clock edge clears the bits, except those set by a step in that cycle.
- R9: A write to offset 0x8 stores the command. Data bit 2 set disables the controller, and all steps are then ignored.
- R10: A write to offset 0xD sets all mask bits and clears the byte pointer, the status bits and the command. Addresses, counts and modes are kept.
- R11: `io_rdata` is combinational. It is 0 when `io_rd` is low or when the offset reads nothing: 0x9 to 0xF, and 0x8 is readable only as status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Port write strobe, one cycle per write |
| io_rd | input | 1 | Port read strobe, one cycle per read |
| io_addr | input | 4 | Port offset |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle `io_rd` is high |
| step_i | input | 4 | Per-channel transfer step, one pulse per transfer |
| mask_o | output | 4 | Per-channel mask state |

## Verification
Read data is due in the same cycle the read strobe is presented, before the clock edge. The read's side effects (the pointer toggle and the status clear) appear only after that edge. Writes and steps change state at the next rising edge, so the first read that can see their effect is the following cycle, and `mask_o` follows one edge after the write or step that moves it. The bench drives every operation at a falling edge and samples one nanosecond later, before the rising edge that commits the operation. Every check therefore sees exactly the state left by the operations before it.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = 2;
  localparam int DW     = 8;
  localparam int RW     = 16;

  localparam logic [3:0] OFS_CMDSTAT = 4'h8;
  localparam logic [3:0] OFS_MASK1   = 4'hA;
  localparam logic [3:0] OFS_MODE    = 4'hB;
  localparam logic [3:0] OFS_PTRCLR  = 4'hC;
  localparam logic [3:0] OFS_MRESET  = 4'hD;
  localparam logic [3:0] OFS_MASKCLR = 4'hE;
  localparam logic [3:0] OFS_MASKALL = 4'hF;

  localparam int MB_AUTO = 4;
  localparam int MB_DOWN = 5;
  localparam int MB_SET  = 2;
  localparam int CB_OFF  = 2;

  typedef struct packed {
    logic autold;
    logic down;
  } ch_mode_t;
endpackage

// File: rtl/dma4_byteptr.sv
module dma4_byteptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic acc,
  output logic hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi <= 1'b0;
    else if (clr) hi <= 1'b0;
    else if (acc) hi <= ~hi;
  end

  // R1
  ptr_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !hi);
  // R2
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !clr) |=> (hi != $past(hi)));
endmodule

// File: rtl/dma4_channel.sv
module dma4_channel #(
  parameter int RW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_addr,
  input  logic          wr_cnt,
  input  logic          hi,
  input  logic [DW-1:0] wdata,
  input  logic          go,
  input  logic          autold,
  input  logic          down,
  output logic [RW-1:0] cur_addr,
  output logic [RW-1:0] cur_cnt,
  output logic          tc_hit
);
  localparam logic [RW-1:0] ONE = RW'(1);

  logic [RW-1:0] base_addr, base_cnt;
  logic          wr_any;

  assign wr_any = wr_addr | wr_cnt;
  assign tc_hit = go && !wr_any && (cur_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
    end else if (wr_addr) begin
      if (hi) begin
        base_addr[RW-1:DW] <= wdata;
        cur_addr[RW-1:DW]  <= wdata;
      end else begin
        base_addr[DW-1:0] <= wdata;
        cur_addr[DW-1:0]  <= wdata;
      end
    end else if (wr_cnt) begin
      if (hi) begin
        base_cnt[RW-1:DW] <= wdata;
        cur_cnt[RW-1:DW]  <= wdata;
      end else begin
        base_cnt[DW-1:0] <= wdata;
        cur_cnt[DW-1:0]  <= wdata;
      end
    end else if (go) begin
      if (tc_hit && autold) begin
        cur_addr <= base_addr;
        cur_cnt  <= base_cnt;
      end else begin
        cur_addr <= down ? cur_addr - ONE : cur_addr + ONE;
        cur_cnt  <= cur_cnt - ONE;
      end
    end
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_any && !go) |=> ($stable(cur_cnt) && $stable(cur_addr)));
  // R6
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !wr_any && cur_cnt != '0) |=> (cur_cnt == $past(cur_cnt) - ONE));
  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_hit && !autold) |=> (cur_cnt == '1));
endmodule

// File: rtl/dma4_regs.sv
module dma4_regs
  import dma4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [3:0]        io_addr,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  input  logic [NUM_CH-1:0] step_i,
  output logic [NUM_CH-1:0] mask_o
);
  logic [NUM_CH-1:0] mask_q, tc_q, tc_hit, go;
  logic              ctl_off;
  logic              hi;
  ch_mode_t          mode_q [NUM_CH];
  logic [RW-1:0]     cur_addr [NUM_CH];
  logic [RW-1:0]     cur_cnt  [NUM_CH];
  logic [DW-1:0]     ch_byte  [NUM_CH*2];

  logic is_chport, ptr_clr, mreset, stat_rd;
  logic [CH_W-1:0] sel_ch;

  assign is_chport = (io_addr[3] == 1'b0);
  assign mreset    = io_wr && (io_addr == OFS_MRESET);
  assign ptr_clr   = io_wr && ((io_addr == OFS_PTRCLR) || (io_addr == OFS_MRESET));
  assign stat_rd   = io_rd && !io_wr && (io_addr == OFS_CMDSTAT);
  assign sel_ch    = io_wdata[CH_W-1:0];
  assign mask_o    = mask_q;

  dma4_byteptr u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ptr_clr),
    .acc  ((io_wr || io_rd) && is_chport),
    .hi   (hi)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic wa, wc;
    assign wa    = io_wr && is_chport && (io_addr[2:0] == 3'(2*g));
    assign wc    = io_wr && is_chport && (io_addr[2:0] == 3'(2*g+1));
    assign go[g] = step_i[g] && !mask_q[g] && !ctl_off;

    dma4_channel #(.RW(RW), .DW(DW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_addr (wa),
      .wr_cnt  (wc),
      .hi      (hi),
      .wdata   (io_wdata),
      .go      (go[g]),
      .autold  (mode_q[g].autold),
      .down    (mode_q[g].down),
      .cur_addr(cur_addr[g]),
      .cur_cnt (cur_cnt[g]),
      .tc_hit  (tc_hit[g])
    );

    assign ch_byte[2*g]   = hi ? cur_addr[g][RW-1:DW] : cur_addr[g][DW-1:0];
    assign ch_byte[2*g+1] = hi ? cur_cnt[g][RW-1:DW]  : cur_cnt[g][DW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[g] <= '0;
      end else if (io_wr && io_addr == OFS_MODE && sel_ch == CH_W'(g)) begin
        mode_q[g].autold <= io_wdata[MB_AUTO];
        mode_q[g].down   <= io_wdata[MB_DOWN];
      end
    end

    // R7
    tc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_hit[g] && !mode_q[g].autold) |=> mask_q[g]);
  end

  // mask register
  logic [NUM_CH-1:0] mask_d;
  always_comb begin
    mask_d = mask_q;
    if (io_wr) begin
      case (io_addr)
        OFS_MASK1:   mask_d[sel_ch] = io_wdata[MB_SET];
        OFS_MASKCLR: mask_d = '0;
        OFS_MASKALL: mask_d = io_wdata[NUM_CH-1:0];
        OFS_MRESET:  mask_d = '1;
        default:     ;
      endcase
    end
    for (int i = 0; i < NUM_CH; i++)
      if (tc_hit[i] && !mode_q[i].autold) mask_d[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      tc_q    <= '0;
      ctl_off <= 1'b0;
    end else begin
      mask_q <= mask_d;
      if (mreset)       tc_q <= '0;
      else if (stat_rd) tc_q <= tc_hit;
      else              tc_q <= tc_q | tc_hit;
      if (mreset)
        ctl_off <= 1'b0;
      else if (io_wr && io_addr == OFS_CMDSTAT)
        ctl_off <= io_wdata[CB_OFF];
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd && !io_wr) begin
      if (is_chport)
        io_rdata = ch_byte[io_addr[2:0]];
      else if (io_addr == OFS_CMDSTAT)
        io_rdata = {{(DW-NUM_CH){1'b0}}, tc_q};
    end
  end

  // R8
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && tc_hit == '0) |=> (tc_q == '0));
  // R9
  ctl_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_off |-> (go == '0));
  // R10
  mreset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |=> (mask_q == '1 && tc_q == '0 && !hi));
  // R11
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == '0));
endmodule

// File: tb/tb_dma4_regs.sv
module tb_dma4_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_wr = 1'b0, io_rd = 1'b0;
  logic [3:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic [3:0] step_i = '0;
  logic [3:0] mask_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  dma4_regs dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .step_i(step_i), .mask_o(mask_o)
  );

  localparam logic [1:0] WR = 2'd0, RD = 2'd1, ST = 2'd2, MK = 2'd3;
  // {op, offset, data, expected, requirement number}
  localparam int NV = 83;
  localparam logic [25:0] VEC [NV] = '{
    {WR,4'hC,8'h00,8'h00,4'd1},   // R1
    {WR,4'h0,8'h34,8'h00,4'd2},   // R2
    {WR,4'h0,8'h12,8'h00,4'd2},
    {WR,4'hC,8'h00,8'h00,4'd1},
    {RD,4'h0,8'h00,8'h34,4'd1},   // R1
    {RD,4'h0,8'h00,8'h12,4'd2},   // R2
    {WR,4'h1,8'h02,8'h00,4'd2},
    {WR,4'h1,8'h00,8'h00,4'd2},
    {WR,4'hB,8'h48,8'h00,4'd5},   // R5 ch0 up, no reload
    {WR,4'hA,8'h00,8'h00,4'd3},
    {MK,4'h0,8'h00,8'h0E,4'd3},   // R3
    {ST,4'h0,8'h01,8'h00,4'd6},
    {ST,4'h0,8'h01,8'h00,4'd6},
    {ST,4'h0,8'h01,8'h00,4'd7},
    {MK,4'h0,8'h00,8'h0F,4'd7},   // R7 self-mask
    {WR,4'hC,8'h00,8'h00,4'd1},
    {RD,4'h0,8'h00,8'h37,4'd6},   // R6
    {RD,4'h0,8'h00,8'h12,4'd6},
    {RD,4'h1,8'h00,8'hFF,4'd7},   // R7 wrap
    {RD,4'h1,8'h00,8'hFF,4'd7},
    {RD,4'h8,8'h00,8'h01,4'd8},   // R8
    {RD,4'h8,8'h00,8'h00,4'd8},
    {WR,4'h2,8'h10,8'h00,4'd2},
    {WR,4'h2,8'h00,8'h00,4'd2},
    {WR,4'h3,8'h01,8'h00,4'd2},
    {WR,4'h3,8'h00,8'h00,4'd2},
    {WR,4'hB,8'h39,8'h00,4'd5},   // R5 ch1 down, reload
    {WR,4'hA,8'h01,8'h00,4'd3},
    {MK,4'h0,8'h00,8'h0D,4'd3},
    {ST,4'h0,8'h02,8'h00,4'd6},
    {WR,4'hC,8'h00,8'h00,4'd1},
    {RD,4'h2,8'h00,8'h0F,4'd5},   // R5 counts down
    {RD,4'h2,8'h00,8'h00,4'd5},
    {ST,4'h0,8'h02,8'h00,4'd7},
    {MK,4'h0,8'h00,8'h0D,4'd7},   // R7 reload keeps mask
    {WR,4'hC,8'h00,8'h00,4'd1},
    {RD,4'h2,8'h00,8'h10,4'd7},
    {RD,4'h2,8'h00,8'h00,4'd7},
    {RD,4'h3,8'h00,8'h01,4'd7},
    {RD,4'h3,8'h00,8'h00,4'd7},
    {RD,4'h8,8'h00,8'h02,4'd8},
    {WR,4'hC,8'h00,8'h00,4'd1},
    {WR,4'h6,8'h77,8'h00,4'd2},
    {WR,4'h6,8'h66,8'h00,4'd2},
    {WR,4'h4,8'hAA,8'h00,4'd2},
    {RD,4'h6,8'h00,8'h66,4'd2},   // R2 shared pointer
    {WR,4'hC,8'h00,8'h00,4'd1},
    {RD,4'h4,8'h00,8'hAA,4'd2},
    {WR,4'hC,8'h00,8'h00,4'd1},
    {ST,4'h0,8'h04,8'h00,4'd6},   // masked ch2
    {RD,4'h5,8'h00,8'h00,4'd6},
    {RD,4'h5,8'h00,8'h00,4'd6},
    {RD,4'h4,8'h00,8'hAA,4'd6},
    {RD,4'h8,8'h00,8'h00,4'd6},
    {WR,4'hF,8'h0A,8'h00,4'd4},
    {MK,4'h0,8'h00,8'h0A,4'd4},   // R4
    {WR,4'hE,8'h00,8'h00,4'd4},
    {MK,4'h0,8'h00,8'h00,4'd4},
    {WR,4'hA,8'h06,8'h00,4'd3},
    {MK,4'h0,8'h00,8'h04,4'd3},
    {WR,4'h8,8'h04,8'h00,4'd9},
    {ST,4'h0,8'h08,8'h00,4'd9},
    {MK,4'h0,8'h00,8'h04,4'd9},   // R9
    {RD,4'h8,8'h00,8'h00,4'd9},
    {WR,4'hC,8'h00,8'h00,4'd1},
    {RD,4'h7,8'h00,8'h00,4'd9},
    {RD,4'h7,8'h00,8'h00,4'd9},
    {WR,4'h8,8'h00,8'h00,4'd9},
    {ST,4'h0,8'h08,8'h00,4'd7},
    {MK,4'h0,8'h00,8'h0C,4'd7},
    {WR,4'hC,8'h00,8'h00,4'd1},
    {WR,4'h6,8'h55,8'h00,4'd10},
    {WR,4'hD,8'h00,8'h00,4'd10},  // R10
    {MK,4'h0,8'h00,8'h0F,4'd10},
    {RD,4'h8,8'h00,8'h00,4'd10},
    {RD,4'h6,8'h00,8'h55,4'd10},
    {RD,4'h6,8'h00,8'h66,4'd10},
    {RD,4'h9,8'h00,8'h00,4'd11},  // R11
    {RD,4'hE,8'h00,8'h00,4'd11},
    {WR,4'hC,8'h00,8'h00,4'd1},
    {WR,4'h2,8'h99,8'h00,4'd2},
    {RD,4'h2,8'h00,8'h00,4'd2},   // R2 reads working high byte
    {RD,4'h3,8'h00,8'h01,4'd2}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [3:0] a, input logic [7:0] d,
                       input logic [7:0] e, input int req);
    @(negedge clk);
    io_wr = (op == WR); io_rd = (op == RD); io_addr = a;
    io_wdata = d; step_i = (op == ST) ? d[3:0] : 4'h0;
    #1;
    if (op == RD) check(io_rdata, e, req);
    if (op == MK) check({4'h0, mask_o}, e, req);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    io_wr = 0; io_rd = 0; step_i = '0; io_addr = '0; io_wdata = '0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // reset state: R4 masks set, R8 status clear, R2 registers zero
    do_op(MK, 4'h0, 8'h00, 8'h0F, 4);
    do_op(RD, 4'h8, 8'h00, 8'h00, 8);
    do_op(RD, 4'h0, 8'h00, 8'h00, 2);
    // R11 read data idle when no read strobe
    idle();
    #1 check(io_rdata, 8'h00, 11);
    for (int i = 0; i < NV; i++)
      do_op(VEC[i][25:24], VEC[i][23:20], VEC[i][19:12], VEC[i][11:4], int'(VEC[i][3:0]));
    idle();
    // R4 mid-run hardware reset restores masks and clears registers
    rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    do_op(MK, 4'h0, 8'h00, 8'h0F, 4);
    do_op(RD, 4'h0, 8'h00, 8'h00, 2);
    do_op(RD, 4'h0, 8'h00, 8'h00, 2);
    idle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule